// File: doc/BRIEF.md
# Two-Lane Compare and Select Unit

This unit treats each 64-bit operand as two independent 32-bit lanes. On every accepted request it compares the two operands lane by lane, using one of five relations. It packs the two lane outcomes, together with their OR and their AND, into a 4-bit condition field.

In the same request a select path can also be enabled. This path builds a 64-bit result lane by lane, taking each lane from the first or the second operand under the control of a 4-bit condition input. That input has the same layout as the field the compare produces, so an earlier compare result can be fed back to steer a later select.

Both results are registered. They appear one cycle after the request, together with a valid flag, and they hold their values until the next request.

Top module: `lane_cmp_sel`

## Requirements
- R1: A request with `inValid` high produces `outValid` high exactly one clock later, and `outValid` is low in any cycle that follows a cycle without a request.
- R2: In `condOut`, bit 3 holds the upper-lane (bits 63:32) compare outcome and bit 2 holds the lower-lane (bits 31:0) outcome.
- R3: `condOut` bit 1 is the OR of the two lane outcomes, and bit 0 is their AND.
- R4: Mode code 0 tests whether the lane of `opA` equals the lane of `opB`.
- R5: Mode code 1 tests signed `opA` > `opB`, and mode code 3 tests signed `opA` < `opB`. Each lane is read as a two's complement number.
- R6: Mode code 2 tests unsigned `opA` > `opB`, and mode code 4 tests unsigned `opA` < `opB`.
- R7: Mode codes 5, 6 and 7 give a `condOut` of 0000.
- R8: With `selEn` high, the upper lane of `selOut` is the upper lane of `opA` when `condIn` bit 3 is set, and the upper lane of `opB` otherwise.
- R9: With `selEn` high, the lower lane of `selOut` is the lower lane of `opA` when `condIn` bit 2 is set, and the lower lane of `opB` otherwise.
- R10: With `selEn` low, a request sets `selOut` to zero.
- R11: While no request arrives, `condOut` and `selOut` keep their last values.
- R12: After reset, `outValid`, `condOut` and `selOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opA | input | 64 | First operand (two 32-bit lanes) |
| opB | input | 64 | Second operand (two 32-bit lanes) |
| modeCode | input | 3 | Compare relation code |
| selEn | input | 1 | Enables the select path |
| condIn | input | 4 | Condition field that steers the select |
| outValid | output | 1 | Results are valid this cycle |
| condOut | output | 4 | Packed compare outcome |
| selOut | output | 64 | Lane-selected result |

## Verification
The hardest cases to reach are the ones where the signed and unsigned readings of a lane disagree. This happens when exactly one of the two lanes being compared has its top bit set, for example 0x7FFFFFFF against 0x80000000, and it must happen in one lane but not the other. Only then can a swapped lane bit or a wrong OR/AND bit show up.

The stimulus walks every mode code through all pairings of the values 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. The upper and lower lanes get different pairings, so the two lane outcomes often differ. The condition input for the select is rotated independently of the compare, so that all four lane choices occur.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;

  typedef enum logic [2:0] {
    MODE_EQ  = 3'd0,
    MODE_GTS = 3'd1,
    MODE_GTU = 3'd2,
    MODE_LTS = 3'd3,
    MODE_LTU = 3'd4
  } cmpMode_e;

  typedef struct packed {
    logic load;
    logic useEq;
    logic useGt;
    logic useLt;
    logic signedCmp;
    logic selOn;
  } ctrlStrobes_t;

endpackage

// File: rtl/lane_cmp_ctl.sv
module lane_cmp_ctl
  import lane_cmp_pkg::*;
(
  input  logic         inValid,
  input  logic [2:0]   modeCode,
  input  logic         selEn,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    strobes.load  = inValid;
    strobes.selOn = selEn;
    case (modeCode)
      MODE_EQ:  strobes.useEq = 1'b1;
      MODE_GTS: begin strobes.useGt = 1'b1; strobes.signedCmp = 1'b1; end
      MODE_GTU: strobes.useGt = 1'b1;
      MODE_LTS: begin strobes.useLt = 1'b1; strobes.signedCmp = 1'b1; end
      MODE_LTU: strobes.useLt = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/lane_cmp_dp.sv
module lane_cmp_dp
  import lane_cmp_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [2*LANE_W-1:0]   opA,
  input  logic [2*LANE_W-1:0]   opB,
  input  logic [3:0]            condIn,
  output logic                  outValid,
  output logic [3:0]            condOut,
  output logic [2*LANE_W-1:0]   selOut
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0]  laneHit;
  logic [DATA_W-1:0] selNext;
  logic [3:0]        condNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] aLane, bLane;
    logic              isEq, aGtB, aLtB;
    logic              topDiffer;

    assign aLane = opA[g*LANE_W +: LANE_W];
    assign bLane = opB[g*LANE_W +: LANE_W];

    // When the top bits differ, the signed reading inverts the unsigned order.
    assign topDiffer = aLane[LANE_W-1] ^ bLane[LANE_W-1];
    assign isEq      = (aLane == bLane);
    assign aGtB      = (aLane > bLane) ^ (strobes.signedCmp & topDiffer);
    assign aLtB      = (aLane < bLane) ^ (strobes.signedCmp & topDiffer);

    assign laneHit[g] = (strobes.useEq & isEq) |
                        (strobes.useGt & aGtB) |
                        (strobes.useLt & aLtB);

    // condIn bit 2 steers lane 0, bit 3 steers lane 1
    assign selNext[g*LANE_W +: LANE_W] =
        !strobes.selOn   ? '0    :
        condIn[2+g]      ? aLane : bLane;
  end

  assign condNext = {laneHit[1], laneHit[0],
                     laneHit[1] | laneHit[0],
                     laneHit[1] & laneHit[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      condOut  <= '0;
      selOut   <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        condOut <= condNext;
        selOut  <= selNext;
      end
    end
  end

endmodule

// File: rtl/lane_cmp_sel.sv
module lane_cmp_sel
  import lane_cmp_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2*LANE_W-1:0] opA,
  input  logic [2*LANE_W-1:0] opB,
  input  logic [2:0]          modeCode,
  input  logic                selEn,
  input  logic [3:0]          condIn,
  output logic                outValid,
  output logic [3:0]          condOut,
  output logic [2*LANE_W-1:0] selOut
);

  ctrlStrobes_t strobes;

  lane_cmp_ctl u_ctl (
    .inValid (inValid),
    .modeCode(modeCode),
    .selEn   (selEn),
    .strobes (strobes)
  );

  lane_cmp_dp #(.LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .condIn  (condIn),
    .outValid(outValid),
    .condOut (condOut),
    .selOut  (selOut)
  );

endmodule

// File: rtl/lane_cmp_sel_chk.sv
module lane_cmp_sel_chk #(
  parameter int LANE_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [2*LANE_W-1:0] opA,
  input logic [2*LANE_W-1:0] opB,
  input logic [2:0]          modeCode,
  input logic                selEn,
  input logic [3:0]          condIn,
  input logic                outValid,
  input logic [3:0]          condOut,
  input logic [2*LANE_W-1:0] selOut
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_eq_upper_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeCode == 3'd0) |=>
      condOut[3] == ($past(opA[2*LANE_W-1:LANE_W]) == $past(opB[2*LANE_W-1:LANE_W])));

  assert_eq_lower_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeCode == 3'd0) |=>
      condOut[2] == ($past(opA[LANE_W-1:0]) == $past(opB[LANE_W-1:0])));

  assert_or_and_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (condOut[1] == (condOut[3] | condOut[2])) &&
                 (condOut[0] == (condOut[3] & condOut[2])));

  assert_unused_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeCode > 3'd4) |=> condOut == 4'b0000);

  assert_sel_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && selEn) |=> selOut[2*LANE_W-1:LANE_W] ==
      ($past(condIn[3]) ? $past(opA[2*LANE_W-1:LANE_W]) : $past(opB[2*LANE_W-1:LANE_W])));

  assert_sel_lower_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && selEn) |=> selOut[LANE_W-1:0] ==
      ($past(condIn[2]) ? $past(opA[LANE_W-1:0]) : $past(opB[LANE_W-1:0])));

  assert_sel_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !selEn) |=> selOut == '0);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(condOut) && $stable(selOut));

endmodule

bind lane_cmp_sel lane_cmp_sel_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .modeCode(modeCode), .selEn(selEn), .condIn(condIn),
  .outValid(outValid), .condOut(condOut), .selOut(selOut)
);

// File: tb/tb_lane_cmp_sel.sv
module tb_lane_cmp_sel;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [63:0] opA, opB;
  logic [2:0]  modeCode;
  logic        selEn;
  logic [3:0]  condIn;
  logic        outValid;
  logic [3:0]  condOut;
  logic [63:0] selOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  cond;
    logic [63:0] sel;
    logic [2:0]  mode;
    logic        selOn;
  } expItem_t;

  expItem_t queueExp[$];
  logic [3:0]  lastCond = '0;
  logic [63:0] lastSel  = '0;

  always #10 clk = ~clk;

  lane_cmp_sel dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .modeCode(modeCode), .selEn(selEn), .condIn(condIn),
    .outValid(outValid), .condOut(condOut), .selOut(selOut)
  );

  // Reference for a single lane compare, written from R4..R7
  function automatic logic refLane(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b);
    case (m)
      3'd0: return a == b;
      3'd1: return $signed(a) > $signed(b);
      3'd2: return a > b;
      3'd3: return $signed(a) < $signed(b);
      3'd4: return a < b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string modeTag(input logic [2:0] m);
    case (m)
      3'd0: return "R4";
      3'd1, 3'd3: return "R5";
      3'd2, 3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic sendReq(input logic [63:0] a, input logic [63:0] b,
                         input logic [2:0] m, input logic s, input logic [3:0] c);
    expItem_t it;
    logic hiHit, loHit;
    @(negedge clk);
    opA = a; opB = b; modeCode = m; selEn = s; condIn = c; inValid = 1'b1;
    hiHit = refLane(m, a[63:32], b[63:32]);
    loHit = refLane(m, a[31:0], b[31:0]);
    // R2 lane bit order, R3 OR/AND
    it.cond  = {hiHit, loHit, hiHit | loHit, hiHit & loHit};
    it.sel   = !s ? 64'd0 : {c[3] ? a[63:32] : b[63:32], c[2] ? a[31:0] : b[31:0]};
    it.mode  = m;
    it.selOn = s;
    queueExp.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = ~opA; modeCode = modeCode + 3'd1; selEn = ~selEn; condIn = ~condIn;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        if (queueExp.size() == 0) begin
          errors++; checks++;
          $display("FAIL R1: unexpected outValid act=1 exp=0");
        end else begin
          expItem_t e;
          e = queueExp.pop_front();
          checks++;
          if (condOut !== e.cond) begin
            errors++;
            $display("FAIL %s/R2/R3 mode=%0d: condOut act=%b exp=%b", modeTag(e.mode), e.mode, condOut, e.cond);
          end
          checks++;
          if (selOut !== e.sel) begin
            errors++;
            $display("FAIL %s: selOut act=%h exp=%h", e.selOn ? "R8/R9" : "R10", selOut, e.sel);
          end
          lastCond = condOut; lastSel = selOut;
        end
      end else if (queueExp.size() != 0) begin
        // item pushed this very edge is expected next cycle; anything older is late
        if (queueExp.size() > 1 || !inValid) begin
          errors++; checks++;
          $display("FAIL R1: outValid act=0 exp=1");
        end
      end else begin
        checks++;
        if (condOut !== lastCond || selOut !== lastSel) begin
          errors++;
          $display("FAIL R11: hold act=%b/%h exp=%b/%h", condOut, selOut, lastCond, lastSel);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [4];
    vals[0] = 32'h0000_0000; vals[1] = 32'h7FFF_FFFF;
    vals[2] = 32'h8000_0000; vals[3] = 32'hFFFF_FFFF;
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0;
    modeCode = '0; selEn = 1'b0; condIn = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (outValid !== 1'b0 || condOut !== 4'd0 || selOut !== 64'd0) begin
      errors++;
      $display("FAIL R12: act=%b/%b/%h exp=0/0000/0", outValid, condOut, selOut);
    end
    @(negedge clk); rstN = 1'b1;

    // Boundary sweep of every mode code (R4 R5 R6 R7), select rotation (R8 R9 R10)
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          sendReq({vals[i], vals[3-j]}, {vals[j], vals[(i+1)%4]},
                  3'(m), ((i + j + m) % 3) != 0, 4'((i * 4 + j + m) % 16));
        end
      end
      idle(2);   // R11 hold and R1 no valid without request
    end

    // Directed: lanes disagree on signedness only
    sendReq({32'h7FFF_FFFF, 32'h0000_0001}, {32'h8000_0000, 32'h8000_0000}, 3'd1, 1'b1, 4'b1000);
    sendReq({32'h7FFF_FFFF, 32'h0000_0001}, {32'h8000_0000, 32'h8000_0000}, 3'd2, 1'b1, 4'b0100);
    sendReq({32'h1234_5678, 32'h9ABC_DEF0}, {32'h0F0F_0F0F, 32'hF0F0_F0F0}, 3'd4, 1'b1, 4'b1100);
    idle(3);
    sendReq({32'hDEAD_BEEF, 32'h0}, {32'hDEAD_BEEF, 32'h0}, 3'd0, 1'b0, 4'b1111);
    idle(3);

    done = 1;
    if (queueExp.size() != 0) begin
      errors++; checks++;
      $display("FAIL R1: pending results act=%0d exp=0", queueExp.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule